// File: doc/BRIEF.md
# Sequenced-Unlock Protected Output Port

This block is an output register on a small synchronous register bus. A single write, such as one from runaway software sweeping the address space, cannot change it. Software must first switch a pin-mode register from general-purpose mode to strobe mode. It then arms a decode register, setting its valid bit with a window field that points at the port. Only then is a port write accepted. Writing zero to the decode register afterwards takes the port out of the address map again.

Each accepted port write produces a one-cycle strobe for the external latch. The external output enable stays low after reset until software has written the inactive value into the port. Writes that break the unlock order are dropped and set a sticky violation flag. Software can read that flag and clear it.

Top module: `guarded_port`

## Requirements
- R1: After reset the pin-mode register reads general-purpose (0), the decode register reads 0x00, the status register reads 0, `port_o` is 0x00 (the inactive value), and `strobe_o`, `oe_o` and `viol_o` are 0.
- R2: Register map on `addr_i`:
  - 0x0 is the pin mode: bit0, 0 = general-purpose, 1 = strobe mode.
  - 0x1 is the decode register: bit7 = valid, bits3:0 = window address.
  - 0x2 is the port.
  - 0x3 is the status register: bit0 = violation.
  - `rdata_o` returns the addressed register combinationally. Unused bits read 0.
- R3: A port write while the port is not armed leaves `port_o` unchanged and produces no strobe.
- R4: The port is armed only when the decode valid bit is 1 and the window field equals 0x2. With the valid bit set and any other window value, a port write is ignored.
- R5: A decode write with bit7 = 1 while the pin mode is general-purpose is ignored, so the decode register keeps its value, and it sets the violation flag. A decode write with bit7 = 0 is accepted in either mode.
- R6: Writing 0x00 to the decode register disarms the port, and later port writes are ignored.
- R7: `strobe_o` is high for exactly the one cycle after each accepted port write. It is never high while the pin mode is general-purpose, because switching back to general-purpose disarms the port.
- R8: `oe_o` stays 0 from reset until the first accepted port write of 0x00. It rises in the cycle after that write and stays high until reset. Accepted writes of other values before that do not raise it.
- R9: `viol_o` (status bit0) is set by a port write that is ignored or by a decode write rejected under R5. It stays set until software writes the status register with bit0 = 1. A status write with bit0 = 0 leaves it set.
- R10: `port_o` and a read of address 0x2 hold the value of the last accepted port write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | DATA_W | Read data of the addressed register |
| port_o | output | DATA_W | Protected port value |
| strobe_o | output | 1 | One-cycle latch strobe after an accepted port write |
| oe_o | output | 1 | External output enable |
| viol_o | output | 1 | Sticky violation flag |

## Verification
A vector table drives write sequences through the whole unlock path:
- a bare port write, which separates the locked path from the armed path;
- a valid-bit write in general-purpose mode, which shows that the pin stage is honoured;
- an armed window that points at the wrong address, which shows that the window match is required and not just the valid bit;
- port writes of a non-inactive value followed by the inactive value, which show that only the inactive value releases the output enable.

Directed tests then cover reset readback, the strobe falling after one cycle, relock by switching back to general-purpose mode, acceptance of a decode write with the valid bit clear, and re-entry into reset with the output enable low again.

// File: rtl/guarded_port_pkg.sv
package guarded_port_pkg;
  typedef enum logic {
    PIN_GPIO = 1'b0,
    PIN_CS   = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/guarded_port_lock.sv
module guarded_port_lock
  import guarded_port_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int PORT_ADDR = 2,
  parameter int PIN_STAGE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_we_i,
  input  logic              dec_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output pin_mode_e         mode_o,
  output logic [DATA_W-1:0] dec_o,
  output logic              armed_o,
  output logic              reject_o
);
  localparam int              ValidBit = DATA_W - 1;
  localparam logic [ADDR_W-1:0] PortA  = ADDR_W'(PORT_ADDR);

  pin_mode_e         mode_q;
  logic [DATA_W-1:0] dec_q;
  logic              cs_ok;

  generate
    if (PIN_STAGE != 0) begin : g_pin_stage
      assign cs_ok = (mode_q == PIN_CS);
    end else begin : g_no_pin_stage
      assign cs_ok = 1'b1;
    end
  endgenerate

  assign reject_o = dec_we_i & wdata_i[ValidBit] & ~cs_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PIN_GPIO;
      dec_q  <= '0;
    end else begin
      if (mode_we_i) mode_q <= pin_mode_e'(wdata_i[0]);
      if (dec_we_i && !reject_o) dec_q <= wdata_i;
    end
  end

  assign armed_o = dec_q[ValidBit] && (dec_q[ADDR_W-1:0] == PortA) && cs_ok;
  assign mode_o  = mode_q;
  assign dec_o   = dec_q;

  // R5
  valid_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PIN_STAGE != 0 && dec_we_i && wdata_i[ValidBit] && mode_q == PIN_GPIO) |=> $stable(dec_q));

  // R6
  relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_we_i && wdata_i == '0) |=> !armed_o);
endmodule

// File: rtl/guarded_port_out.sv
module guarded_port_out #(
  parameter int DATA_W   = 8,
  parameter int INACTIVE = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              armed_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] port_o,
  output logic              strobe_o,
  output logic              oe_o,
  output logic              reject_o
);
  localparam logic [DATA_W-1:0] InactV = DATA_W'(INACTIVE);

  logic [DATA_W-1:0] port_q;
  logic              strobe_q, oe_q, accept;

  assign accept   = we_i & armed_i;
  assign reject_o = we_i & ~armed_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_q   <= InactV;
      strobe_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      strobe_q <= accept;
      if (accept) port_q <= wdata_i;
      if (accept && wdata_i == InactV) oe_q <= 1'b1;
    end
  end

  assign port_o   = port_q;
  assign strobe_o = strobe_q;
  assign oe_o     = oe_q;

  // R3
  locked_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !armed_i) |=> !strobe_q);

  // R8
  oe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |=> oe_q);

  // R8
  oe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_q) |-> $past(armed_i && we_i && wdata_i == InactV));

  // R10
  port_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && armed_i) |=> $stable(port_q));
endmodule

// File: rtl/guarded_port_viol.sv
module guarded_port_viol (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_a_i,
  input  logic set_b_i,
  input  logic clr_i,
  output logic viol_o
);
  logic viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 viol_q <= 1'b0;
    else if (set_a_i || set_b_i) viol_q <= 1'b1;
    else if (clr_i)              viol_q <= 1'b0;
  end

  assign viol_o = viol_q;

  // R9
  viol_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_a_i || set_b_i) |=> viol_q);

  // R9
  viol_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_q && !clr_i) |=> viol_q);
endmodule

// File: rtl/guarded_port.sv
module guarded_port
  import guarded_port_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int INACTIVE  = 0,
  parameter int PIN_STAGE = 1,
  parameter int MODE_ADDR = 0,
  parameter int DEC_ADDR  = 1,
  parameter int PORT_ADDR = 2,
  parameter int STAT_ADDR = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] port_o,
  output logic              strobe_o,
  output logic              oe_o,
  output logic              viol_o
);
  localparam logic [ADDR_W-1:0] ModeA = ADDR_W'(MODE_ADDR);
  localparam logic [ADDR_W-1:0] DecA  = ADDR_W'(DEC_ADDR);
  localparam logic [ADDR_W-1:0] PortA = ADDR_W'(PORT_ADDR);
  localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_ADDR);

  logic              mode_we, dec_we, port_we, stat_we;
  logic              armed, dec_rej, port_rej;
  pin_mode_e         mode;
  logic [DATA_W-1:0] dec;

  assign mode_we = we_i && addr_i == ModeA;
  assign dec_we  = we_i && addr_i == DecA;
  assign port_we = we_i && addr_i == PortA;
  assign stat_we = we_i && addr_i == StatA;

  guarded_port_lock #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR), .PIN_STAGE(PIN_STAGE)
  ) u_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_we_i(mode_we), .dec_we_i(dec_we),
    .wdata_i(wdata_i), .mode_o(mode), .dec_o(dec), .armed_o(armed), .reject_o(dec_rej)
  );

  guarded_port_out #(.DATA_W(DATA_W), .INACTIVE(INACTIVE)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(port_we), .armed_i(armed), .wdata_i(wdata_i),
    .port_o(port_o), .strobe_o(strobe_o), .oe_o(oe_o), .reject_o(port_rej)
  );

  guarded_port_viol u_viol (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_a_i(port_rej), .set_b_i(dec_rej),
    .clr_i(stat_we && wdata_i[0]), .viol_o(viol_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ModeA)      rdata_o[0] = logic'(mode);
    else if (addr_i == DecA)  rdata_o = dec;
    else if (addr_i == PortA) rdata_o = port_o;
    else if (addr_i == StatA) rdata_o[0] = viol_o;
  end

  // R7
  strobe_gpio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (PIN_STAGE != 0 && strobe_o) |-> $past(mode == PIN_CS && port_we));
endmodule

// File: tb/guarded_port_tb_top.sv
`timescale 1ns/1ps
module guarded_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       we = 1'b0;
  logic [7:0] rdata, port;
  logic       strobe, oe, viol;
  int         total = 0;
  int         bad = 0;

  always #10 clk = ~clk;

  guarded_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .port_o(port), .strobe_o(strobe), .oe_o(oe), .viol_o(viol)
  );

  typedef struct packed {
    logic [3:0] a;
    logic [7:0] d;
    logic [7:0] port;
    logic       stb;
    logic       oe;
    logic       viol;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'h2, 8'h55, 8'h00, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 locked port write
    '{4'h3, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 clear
    '{4'h1, 8'h82, 8'h00, 1'b0, 1'b0, 1'b1, 4'd5},  // R5 valid in gpio
    '{4'h3, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 4'd9},
    '{4'h0, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 mode to strobe
    '{4'h1, 8'h83, 8'h00, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 wrong window
    '{4'h2, 8'hA5, 8'h00, 1'b0, 1'b0, 1'b1, 4'd4},
    '{4'h3, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0, 4'd9},
    '{4'h1, 8'h82, 8'h00, 1'b0, 1'b0, 1'b0, 4'd4},  // armed
    '{4'h2, 8'h3C, 8'h3C, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 non-inactive
    '{4'h2, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 inactive -> oe
    '{4'h2, 8'hF0, 8'hF0, 1'b1, 1'b1, 1'b0, 4'd10}, // R10
    '{4'h1, 8'h00, 8'hF0, 1'b0, 1'b1, 1'b0, 4'd6},  // R6 relock
    '{4'h2, 8'h11, 8'hF0, 1'b0, 1'b1, 1'b1, 4'd6},
    '{4'h3, 8'h00, 8'hF0, 1'b0, 1'b1, 1'b1, 4'd9},  // R9 bit0=0 keeps
    '{4'h3, 8'h01, 8'hF0, 1'b0, 1'b1, 1'b0, 4'd9}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 oe", oe, 0); check("R1 strobe", strobe, 0);
    check("R1 viol", viol, 0); check("R1 port", port, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(4'h0, r); check("R1 mode read", r, 8'h00);
    rd(4'h1, r); check("R1 decode read", r, 8'h00);
    rd(4'h3, r); check("R1 status read", r, 8'h00);
    rd(4'h2, r); check("R2 port read", r, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].a, VECS[i].d);
      check($sformatf("R%0d vec%0d port", VECS[i].req, i), port, VECS[i].port);
      check($sformatf("R%0d vec%0d strobe", VECS[i].req, i), strobe, VECS[i].stb);
      check($sformatf("R%0d vec%0d oe", VECS[i].req, i), oe, VECS[i].oe);
      check($sformatf("R%0d vec%0d viol", VECS[i].req, i), viol, VECS[i].viol);
      if (i == 2) begin
        rd(4'h1, r); check("R5 decode kept after reject", r, 8'h00);
      end
    end

    // R7 strobe lasts one cycle; R10 readback
    wr(4'h1, 8'h82);
    wr(4'h2, 8'h5A);
    check("R7 strobe high", strobe, 1);
    @(negedge clk);
    check("R7 strobe one cycle", strobe, 0);
    rd(4'h2, r); check("R10 port readback", r, 8'h5A);
    rd(4'h0, r); check("R2 mode readback", r, 8'h01);

    // R7 back to gpio disarms
    wr(4'h0, 8'h00);
    wr(4'h2, 8'h77);
    check("R7 no strobe in gpio", strobe, 0);
    check("R7 port unchanged in gpio", port, 8'h5A);
    check("R9 viol on gpio port write", viol, 1);
    wr(4'h3, 8'h01);

    // R5 valid=0 write accepted in gpio
    wr(4'h1, 8'h05);
    rd(4'h1, r); check("R5 clear-valid write accepted", r, 8'h05);
    check("R5 no viol for valid=0", viol, 0);

    // R8 reset drops oe again
    check("R8 oe before reset", oe, 1);
    rst_ni = 1'b0;
    #2;
    check("R8 oe after reset", oe, 0);
    check("R1 port after reset", port, 8'h00);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R8 oe stays low", oe, 0);

    finish_run();
  end
endmodule